// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the 32-bit program counter of a simple in-order core and works out, each cycle, the address of the next instruction. It looks at the fetched instruction word and at the two register operand values that were read for it. From these it picks one of four kinds of next address:

- the next sequential word,
- a PC-relative conditional branch target,
- an absolute jump target that stays inside the current 256 MB region,
- a full 32-bit address taken from a register.

For jump-and-link it also presents the return address and a write strobe. Register file writes, instruction memory and all arithmetic on data belong to the neighbouring blocks.

A branch offset counts instructions, not bytes, and is applied to the address of the following instruction. An absolute jump takes its low 28 address bits from the instruction, with the two lowest bits forced to zero. It keeps the upper four bits of the current PC. A low enable freezes the PC, so the pipeline can stall fetch.

Top module: `pcu_next_addr`

## Requirements
- R1: With `rst_n` low at a rising clock edge, the PC loads the parameter `RESET_VEC`, whatever the value of `en`.
- R2: With `rst_n` high and `en` low at a rising edge, the PC keeps its value.
- R3: An instruction that is not a branch or jump advances the PC by 4. This covers opcode 0 with a funct field (bits [5:0]) other than 8, and every opcode outside {0,2,3,4,5}. The opcode is bits [31:26].
- R4: Opcode 4 (branch-if-equal) with `rs_val == rt_val` sets the PC to PC + 4 + (sign-extended bits [15:0]) × 4, modulo 2^32. For example, an immediate of 3 moves the PC forward by 16.
- R5: A conditional branch whose condition is false advances the PC by 4.
- R6: Opcode 5 (branch-if-not-equal) with `rs_val != rt_val` sets the PC to the same target as in R4.
- R7: Opcode 2 (jump) sets the PC to {PC[31:28], instruction[25:0], 2'b00}.
- R8: Opcode 3 (jump-and-link) jumps as in R7. During that cycle `link_val` equals PC + 4, not PC + 8.
- R9: Opcode 0 with funct 8 (jump-to-register) loads all 32 bits of `rs_val` into the PC.
- R10: `link_we` is high exactly when `en` is high and the opcode is 3. `link_val` equals the current PC + 4 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Advance enable; low stalls the PC |
| instr | input | 32 | Fetched instruction word for the current PC |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| pc | output | 32 | Current program counter |
| link_we | output | 1 | Return-address write strobe for register 31 |
| link_val | output | 32 | Return address (PC + 4) |

## Verification
The bench builds the unit with `RESET_VEC` set to 32'hF000_0100 rather than the zero default. This way the first jumps after reset must keep a nonzero upper nibble, and a dropped or misplaced region field shows up at once. From there, jump-to-register steers the PC to 32'hFFFF_FFF8 and to 32'h0FFF_FFFC. These two addresses cover a forward branch that wraps past the top of the address space, a sequential step that carries into the region bits, and a later jump that must keep the new region. Random instruction mixes, with operands forced equal half the time, cover both outcomes of each branch kind.

// File: rtl/pcu_pkg.sv
// Package pcu_pkg
// Shared field positions, opcode values and the flow-kind type for the
// next-address unit. Assumes the fixed 32-bit instruction layout.
package pcu_pkg;

    localparam int INSTR_W  = 32;
    localparam int OPC_W    = 6;
    localparam int FUNCT_W  = 6;
    localparam int OFF_W    = 16;
    localparam int TGT_W    = 26;
    localparam int OPC_LSB  = INSTR_W - OPC_W;
    localparam int ALIGN_W  = 2;

    localparam logic [OPC_W-1:0]   OPC_SPECIAL = 6'd0;
    localparam logic [OPC_W-1:0]   OPC_JMP     = 6'd2;
    localparam logic [OPC_W-1:0]   OPC_JAL     = 6'd3;
    localparam logic [OPC_W-1:0]   OPC_BEQ     = 6'd4;
    localparam logic [OPC_W-1:0]   OPC_BNE     = 6'd5;
    localparam logic [FUNCT_W-1:0] FN_JREG     = 6'd8;

    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_BEQ,
        FLOW_BNE,
        FLOW_JMP,
        FLOW_JAL,
        FLOW_JREG
    } flow_e;

endpackage

// File: rtl/pcu_decode.sv
// Module pcu_decode
// Classifies the instruction into one flow kind from its opcode and, for
// the special opcode, its funct field. Purely combinational. Any encoding
// it does not recognise is treated as sequential.
module pcu_decode
    import pcu_pkg::*;
(
    input  logic [OPC_W-1:0]   opcode,
    input  logic [FUNCT_W-1:0] funct,
    output flow_e              flow
);

    // Map the opcode/funct pair onto a flow kind.
    always_comb begin
        unique case (opcode)
            OPC_BEQ:     flow = FLOW_BEQ;
            OPC_BNE:     flow = FLOW_BNE;
            OPC_JMP:     flow = FLOW_JMP;
            OPC_JAL:     flow = FLOW_JAL;
            OPC_SPECIAL: flow = (funct == FN_JREG) ? FLOW_JREG : FLOW_SEQ;
            default:     flow = FLOW_SEQ;
        endcase
    end

endmodule

// File: rtl/pcu_addr_gen.sv
// Module pcu_addr_gen
// Builds the candidate addresses from the current PC: the sequential
// address, the PC-relative branch target (offset in words, added to PC+4)
// and the region-absolute jump target. Assumes XLEN exceeds the jump
// field plus alignment bits.
module pcu_addr_gen
    import pcu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    input  logic [TGT_W-1:0] target,
    output logic [XLEN-1:0]  seq_addr,
    output logic [XLEN-1:0]  branch_addr,
    output logic [XLEN-1:0]  jump_addr
);

    localparam int EXT_W    = XLEN - OFF_W - ALIGN_W;
    localparam int REGION_W = XLEN - TGT_W - ALIGN_W;
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0] offset_bytes;

    // Sign-extend the word offset and scale it to bytes.
    always_comb begin
        offset_bytes = {{EXT_W{offset[OFF_W-1]}}, offset, {ALIGN_W{1'b0}}};
    end

    // Sequential and branch adders; both wrap modulo 2^XLEN.
    always_comb begin
        seq_addr    = pc + STEP;
        branch_addr = seq_addr + offset_bytes;
    end

    // Keep the region bits of the PC and splice in the word target.
    always_comb begin
        jump_addr = {pc[XLEN-1 -: REGION_W], target, {ALIGN_W{1'b0}}};
    end

endmodule

// File: rtl/pcu_select.sv
// Module pcu_select
// Chooses the next PC from the candidate addresses, given the flow kind
// and the register comparison. Also raises the link request for
// jump-and-link. Combinational; the caller gates it with the enable.
module pcu_select
    import pcu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  flow_e           flow,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    input  logic [XLEN-1:0] seq_addr,
    input  logic [XLEN-1:0] branch_addr,
    input  logic [XLEN-1:0] jump_addr,
    output logic [XLEN-1:0] next_pc,
    output logic            link_req
);

    logic ops_equal;

    // Equality compare of the two register operands.
    always_comb begin
        ops_equal = (rs_val == rt_val);
    end

    // Next-address multiplexer.
    always_comb begin
        unique case (flow)
            FLOW_BEQ:  next_pc = ops_equal  ? branch_addr : seq_addr;
            FLOW_BNE:  next_pc = !ops_equal ? branch_addr : seq_addr;
            FLOW_JMP:  next_pc = jump_addr;
            FLOW_JAL:  next_pc = jump_addr;
            FLOW_JREG: next_pc = rs_val;
            default:   next_pc = seq_addr;
        endcase
    end

    // Only jump-and-link asks for a return-address write.
    always_comb begin
        link_req = (flow == FLOW_JAL);
    end

endmodule

// File: rtl/pcu_pc_reg.sv
// Module pcu_pc_reg
// The program counter register. Synchronous active-low reset to RESET_VEC
// takes priority over the enable. With the enable low the value holds.
module pcu_pc_reg #(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] RESET_VEC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [XLEN-1:0] d,
    output logic [XLEN-1:0] q
);

    // Reset, load or hold the PC on each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RESET_VEC;
        end else if (en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/pcu_next_addr.sv
// Module pcu_next_addr (top)
// Program counter with next-address selection for sequential flow,
// equal/not-equal branches, region jumps with and without link, and
// jump-to-register. Assumes the instruction and operands are valid in the
// cycle they are presented. No delay slot, no traps.
module pcu_next_addr
    import pcu_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [INSTR_W-1:0] instr,
    input  logic [XLEN-1:0]    rs_val,
    input  logic [XLEN-1:0]    rt_val,
    output logic [XLEN-1:0]    pc,
    output logic               link_we,
    output logic [XLEN-1:0]    link_val
);

    flow_e           flow;
    logic [XLEN-1:0] seq_addr;
    logic [XLEN-1:0] branch_addr;
    logic [XLEN-1:0] jump_addr;
    logic [XLEN-1:0] next_pc;
    logic            link_req;

    pcu_decode u_decode (
        .opcode (instr[INSTR_W-1:OPC_LSB]),
        .funct  (instr[FUNCT_W-1:0]),
        .flow   (flow)
    );

    pcu_addr_gen #(.XLEN(XLEN)) u_addr_gen (
        .pc          (pc),
        .offset      (instr[OFF_W-1:0]),
        .target      (instr[TGT_W-1:0]),
        .seq_addr    (seq_addr),
        .branch_addr (branch_addr),
        .jump_addr   (jump_addr)
    );

    pcu_select #(.XLEN(XLEN)) u_select (
        .flow        (flow),
        .rs_val      (rs_val),
        .rt_val      (rt_val),
        .seq_addr    (seq_addr),
        .branch_addr (branch_addr),
        .jump_addr   (jump_addr),
        .next_pc     (next_pc),
        .link_req    (link_req)
    );

    pcu_pc_reg #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) u_pc_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .d     (next_pc),
        .q     (pc)
    );

    // Return address and its strobe; a stalled cycle writes nothing.
    always_comb begin
        link_val = seq_addr;
        link_we  = en & link_req;
    end

endmodule

// File: rtl/pcu_sva.sv
// Module pcu_sva
// Checker for pcu_next_addr, attached by bind. It relates the PC across
// clock edges to the inputs of the previous cycle, and checks the link
// outputs within each cycle.
module pcu_sva #(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] RESET_VEC = '0
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en,
    input logic [31:0]     instr,
    input logic [XLEN-1:0] rs_val,
    input logic [XLEN-1:0] rt_val,
    input logic [XLEN-1:0] pc,
    input logic            link_we,
    input logic [XLEN-1:0] link_val
);

    logic [5:0]      op;
    logic            is_jreg;
    logic            is_plain;
    logic [XLEN-1:0] off_b;

    assign op       = instr[31:26];
    assign is_jreg  = (op == 6'd0) && (instr[5:0] == 6'd8);
    assign is_plain = !(op inside {6'd2, 6'd3, 6'd4, 6'd5}) && !is_jreg;
    assign off_b    = {{(XLEN-18){instr[15]}}, instr[15:0], 2'b00};

    p_reset_vec_r1: assert property (@(posedge clk)
        !rst_n |=> pc == RESET_VEC);

    p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(pc));

    p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && is_plain) |=> pc == $past(pc) + XLEN'(4));

    p_beq_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == 6'd4 && rs_val == rt_val)
        |=> pc == $past(pc) + XLEN'(4) + $past(off_b));

    p_branch_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ((op == 6'd4 && rs_val != rt_val) || (op == 6'd5 && rs_val == rt_val)))
        |=> pc == $past(pc) + XLEN'(4));

    p_bne_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == 6'd5 && rs_val != rt_val)
        |=> pc == $past(pc) + XLEN'(4) + $past(off_b));

    p_jump_region_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (op == 6'd2 || op == 6'd3))
        |=> (pc[XLEN-1:XLEN-4] == $past(pc[XLEN-1:XLEN-4]))
            && (pc[27:0] == {$past(instr[25:0]), 2'b00}));

    p_link_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> link_val == pc + XLEN'(4));

    p_jreg_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && is_jreg) |=> pc == $past(rs_val));

    p_link_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        link_we == (en && op == 6'd3));

endmodule

bind pcu_next_addr pcu_sva #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) u_pcu_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .instr    (instr),
    .rs_val   (rs_val),
    .rt_val   (rt_val),
    .pc       (pc),
    .link_we  (link_we),
    .link_val (link_val)
);

// File: tb/tb_pcu_next_addr.sv
// Bench for pcu_next_addr: directed corner cases, then seeded random mixes.
// Inputs change after the falling edge; outputs are checked after the next
// falling edge.
module tb_pcu_next_addr;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] RST_VEC    = 32'hF000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [31:0] pc;
    logic        link_we;
    logic [31:0] link_val;

    int          n_checks = 0;
    int          n_fail = 0;
    logic [31:0] model_pc = RST_VEC;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcu_next_addr #(.XLEN(32), .RESET_VEC(RST_VEC)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .instr    (instr),
        .rs_val   (rs_val),
        .rt_val   (rt_val),
        .pc       (pc),
        .link_we  (link_we),
        .link_val (link_val)
    );

    // Next PC as the requirements define it.
    function automatic logic [31:0] f_next(input logic [31:0] p, input logic [31:0] ins,
                                           input logic [31:0] a, input logic [31:0] b);
        logic [31:0] seq;
        logic [31:0] br;
        seq = p + 32'd4;
        br  = seq + ({{16{ins[15]}}, ins[15:0]} << 2);
        case (ins[31:26])
            6'd4:       return (a == b) ? br : seq;
            6'd5:       return (a != b) ? br : seq;
            6'd2, 6'd3: return {p[31:28], ins[25:0], 2'b00};
            6'd0:       return (ins[5:0] == 6'd8) ? a : seq;
            default:    return seq;
        endcase
    endfunction

    // Requirement tag for a given stimulus.
    function automatic string f_req(input logic [31:0] ins, input logic [31:0] a,
                                    input logic [31:0] b, input logic e, input logic r);
        if (!r) return "R1";
        if (!e) return "R2";
        case (ins[31:26])
            6'd4:    return (a == b) ? "R4" : "R5";
            6'd5:    return (a != b) ? "R6" : "R5";
            6'd2:    return "R7";
            6'd3:    return "R8";
            6'd0:    return (ins[5:0] == 6'd8) ? "R9" : "R3";
            default: return "R3";
        endcase
    endfunction

    task automatic check32(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One cycle: drive, check link outputs, clock, check PC.
    task automatic step(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                        input logic e, input logic r);
        logic [31:0] nxt;
        string       req;
        instr = ins; rs_val = a; rt_val = b; en = e; rst_n = r;
        #1;
        req = f_req(ins, a, b, e, r);
        check32("R10", "link_we", {31'd0, link_we}, {31'd0, e && ins[31:26] == 6'd3});
        check32((ins[31:26] == 6'd3) ? "R8" : "R10", "link_val", link_val, model_pc + 32'd4);
        nxt = !r ? RST_VEC : (!e ? model_pc : f_next(model_pc, ins, a, b));
        @(posedge clk);
        @(negedge clk);
        check32(req, "pc", pc, nxt);
        model_pc = nxt;
    endtask

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [25:0] rest);
        return {op, rest};
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] nop;
        nop = mk(6'd0, 26'h20);            // special, funct 32: sequential
        @(negedge clk);
        // R1: reset with enable low still loads the vector
        step(nop, 0, 0, 1'b0, 1'b0);
        step(nop, 0, 0, 1'b1, 1'b0);
        // R3: sequential steps, including an unknown opcode
        step(nop, 0, 0, 1'b1, 1'b1);
        step(mk(6'd35, 26'h0), 0, 0, 1'b1, 1'b1);
        // R2: stall holds even for a jump
        step(mk(6'd2, 26'h123), 0, 0, 1'b0, 1'b1);
        // R7: jump keeps region F
        step(mk(6'd2, 26'h0000040), 0, 0, 1'b1, 1'b1);
        // R4: branch-equal, rs=9 rt=0 imm=3 -> +16
        step({6'd4, 5'd9, 5'd0, 16'd3}, 32'h55, 32'h55, 1'b1, 1'b1);
        // R5: branch-equal not taken
        step({6'd4, 5'd9, 5'd0, 16'd3}, 32'h55, 32'h56, 1'b1, 1'b1);
        // R6: branch-not-equal backward
        step({6'd5, 5'd1, 5'd2, 16'hFFFE}, 32'h1, 32'h2, 1'b1, 1'b1);
        // R5: branch-not-equal not taken
        step({6'd5, 5'd1, 5'd2, 16'hFFFE}, 32'h7, 32'h7, 1'b1, 1'b1);
        // R8: jump-and-link
        step(mk(6'd3, 26'h3FFFFFF), 0, 0, 1'b1, 1'b1);
        // R9: jump-to-register near top, then wrapping branch
        step(mk(6'd0, 26'h8), 32'hFFFF_FFF8, 0, 1'b1, 1'b1);
        step({6'd4, 5'd0, 5'd0, 16'd3}, 0, 0, 1'b1, 1'b1);
        // R3 carry into region bits, then R7 keeps the new region
        step(mk(6'd0, 26'h8), 32'h0FFF_FFFC, 0, 1'b1, 1'b1);
        step(nop, 0, 0, 1'b1, 1'b1);
        step(mk(6'd2, 26'h10), 0, 0, 1'b1, 1'b1);
        // R10: stalled jump-and-link gives no strobe
        step(mk(6'd3, 26'h10), 0, 0, 1'b0, 1'b1);

        void'($urandom(32'd2024));
        for (int i = 0; i < 3000; i++) begin
            logic [5:0]  op;
            logic [25:0] rest;
            logic [31:0] a;
            logic [31:0] b;
            logic        e;
            logic        r;
            case ($urandom_range(0, 7))
                0: op = 6'd0;
                1: op = 6'd2;
                2: op = 6'd3;
                3, 4: op = 6'd4;
                5: op = 6'd5;
                default: op = 6'($urandom_range(0, 63));
            endcase
            rest = 26'($urandom);
            if (op == 6'd0 && $urandom_range(0, 1) == 1) rest[5:0] = 6'd8;
            a = $urandom;
            b = ($urandom_range(0, 1) == 1) ? a : $urandom;
            e = ($urandom_range(0, 9) != 0);
            r = ($urandom_range(0, 99) != 0);
            step({op, rest}, a, b, e, r);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule